// File: doc/BRIEF.md
# Frame-Sync Realigning Serial Word Receiver

This block turns a one-bit serial audio stream into parallel words. It runs on the bit clock. On every rising edge of that clock it samples the serial data line and the frame-sync line, and shifts the data bit into a word assembler, most significant bit first. An internal bit position counter runs modulo a configured frame length of two words. Each time that counter reaches the last bit of a word, the assembled word goes to a registered output with a one-cycle valid strobe.

After reset the counter starts from a preset value instead of zero, so until the first frame sync arrives the word boundaries fall at an arbitrary offset. Every word captured in that state is the sender's stream rotated by that offset. A rising edge on the frame-sync line makes the next sampled bit the first bit of word 0. The first such edge also raises a sticky lock flag. When the sender uses a longer frame than the receiver, for example four-slot frames of 128 bits against a 64-bit receive frame, the receiver free-runs across its own frame wrap without error and realigns on every second receive frame.

Top module: `lrck_word_rx`

## Requirements
- R1: While `rst` is high at a clock edge, `word_valid`, `locked` and `word_data` become 0 after that edge, and the bit counter is loaded with `PRESET`.
- R2: Serial bits enter MSB first. When the bit sampled at an edge is bit 31 of a word, `word_data` holds that bit and the 31 bits sampled before it, after that same edge, with `word_valid` high.
- R3: With no frame-sync edge after reset, the first word completes on the (32 − PRESET mod 32)-th bit sampled after reset is released. Later words follow every 32 bits, so the sender's words appear rotated by PRESET mod 32 bit positions.
- R4: A frame-sync rising edge is a sample of 1 on `frame_sync` whose previous sample was 0. The bit sampled in the cycle after the edge becomes bit 31 (MSB) of word 0. The bit sampled in the edge cycle itself is still handled under the old count, and it completes a word if it was that word's last bit. A partly assembled word is dropped.
- R5: The bit counter runs modulo `FRAME_BITS` (64). At the wrap it continues into word 0 with no edge and no gap. A 128-bit, four-slot stream with one edge per frame therefore yields all four slots aligned.
- R6: `locked` rises after the first frame-sync rising edge and stays high until reset. A falling edge, a level held high, and a `frame_sync` that is already high when reset is released are not edges.
- R7: `word_valid` is high for exactly one cycle per word. `word_data` changes only in cycles where `word_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; all sampling on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame-sync line; a rising edge realigns the word boundary |
| serial_in | input | 1 | Serial data, MSB first |
| word_data | output | WORD_BITS | Last completed word |
| word_valid | output | 1 | One-cycle strobe for a new `word_data` |
| locked | output | 1 | Sticky: a frame-sync edge has been seen since reset |

## Verification
Two functions can fall in the same clock edge. One is the completion of a word by the last bit of the fourth slot. The other is the frame-sync rising edge that forces the counter back to word 0. The bench provokes this in every synced 128-bit frame, because the sync rises during that final bit. It judges the edge by requiring the slot-3 word to be delivered intact and the next word to equal slot 0. A second case injects a short run of filler bits, so that an edge arrives in the middle of a word. After it the partial word must never appear and alignment must return at once. A behavioural model updated on every clock compares all three outputs in every cycle.

// File: rtl/lwr_pkg.sv
package lwr_pkg;
  // Width of a counter that indexes n positions (at least 1 bit).
  function automatic int unsigned idx_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/lwr_sync_detect.sv
module lwr_sync_detect (
  input  logic clk,
  input  logic rst,
  input  logic frame_sync,
  output logic sync_edge,
  output logic locked
);
  logic fs_prev;

  // Previous sample resets to 1 so a line already high at reset is no edge.
  always_ff @(posedge clk) begin
    if (rst) fs_prev <= 1'b1;
    else     fs_prev <= frame_sync;
  end

  assign sync_edge = frame_sync & ~fs_prev & ~rst;

  always_ff @(posedge clk) begin
    if (rst)            locked <= 1'b0;
    else if (sync_edge) locked <= 1'b1;
  end
endmodule

// File: rtl/lwr_bit_counter.sv
module lwr_bit_counter #(
  parameter int unsigned WORD_BITS  = 32,
  parameter int unsigned FRAME_BITS = 64,
  parameter int unsigned PRESET     = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_edge,
  output logic word_end
);
  localparam int unsigned CW = lwr_pkg::idx_width(FRAME_BITS);
  localparam int unsigned WW = lwr_pkg::idx_width(WORD_BITS);
  localparam logic [CW-1:0] LAST   = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] START  = CW'(PRESET % FRAME_BITS);
  localparam logic [WW-1:0] W_LAST = WW'(WORD_BITS - 1);

  logic [CW-1:0] pos;

  always_ff @(posedge clk) begin
    if (rst)               pos <= START;
    else if (sync_edge)    pos <= '0;
    else if (pos == LAST)  pos <= '0;
    else                   pos <= pos + 1'b1;
  end

  // Word boundary uses the count held before this edge.
  assign word_end = (pos[WW-1:0] == W_LAST) & ~rst;
endmodule

// File: rtl/lwr_word_shifter.sv
module lwr_word_shifter #(
  parameter int unsigned WORD_BITS = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 serial_in,
  input  logic                 word_end,
  output logic [WORD_BITS-1:0] word_data,
  output logic                 word_valid
);
  logic [WORD_BITS-2:0] acc;

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= {acc[WORD_BITS-3:0], serial_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_data  <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= word_end;
      if (word_end) word_data <= {acc, serial_in};
    end
  end
endmodule

// File: rtl/lrck_word_rx.sv
module lrck_word_rx #(
  parameter int unsigned WORD_BITS  = 32,
  parameter int unsigned FRAME_BITS = 64,
  parameter int unsigned PRESET     = 13
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 frame_sync,
  input  logic                 serial_in,
  output logic [WORD_BITS-1:0] word_data,
  output logic                 word_valid,
  output logic                 locked
);
  logic sync_edge;
  logic word_end;

  lwr_sync_detect u_sync (
    .clk        (clk),
    .rst        (rst),
    .frame_sync (frame_sync),
    .sync_edge  (sync_edge),
    .locked     (locked)
  );

  lwr_bit_counter #(
    .WORD_BITS  (WORD_BITS),
    .FRAME_BITS (FRAME_BITS),
    .PRESET     (PRESET)
  ) u_count (
    .clk       (clk),
    .rst       (rst),
    .sync_edge (sync_edge),
    .word_end  (word_end)
  );

  lwr_word_shifter #(
    .WORD_BITS (WORD_BITS)
  ) u_shift (
    .clk        (clk),
    .rst        (rst),
    .serial_in  (serial_in),
    .word_end   (word_end),
    .word_data  (word_data),
    .word_valid (word_valid)
  );
endmodule

// File: rtl/lwr_checker.sv
module lwr_checker #(
  parameter int unsigned WORD_BITS = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 frame_sync,
  input logic [WORD_BITS-1:0] word_data,
  input logic                 word_valid,
  input logic                 locked
);
  // R1: reset clears strobe and lock
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!word_valid && !locked));

  // R7: strobe never lasts two cycles
  p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  // R7: data only moves with the strobe
  p_data_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !word_valid |-> $stable(word_data));

  // R6: lock is sticky
  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  // R6: lock only rises after frame_sync was sampled high
  p_lock_cause_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(frame_sync));
endmodule

bind lrck_word_rx lwr_checker #(.WORD_BITS(WORD_BITS)) u_lwr_chk (
  .clk        (clk),
  .rst        (rst),
  .frame_sync (frame_sync),
  .word_data  (word_data),
  .word_valid (word_valid),
  .locked     (locked)
);

// File: tb/lrck_word_rx_test.sv
module lrck_word_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int WORD   = 32;
  localparam int FRAME  = 64;
  localparam int PRESET = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_sync = 1'b0;
  logic serial_in = 1'b0;
  logic [WORD-1:0] word_data;
  logic word_valid;
  logic locked;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  int        m_cnt;
  bit        m_prev, m_lock, m_valid;
  logic [31:0] m_sr, m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  lrck_word_rx #(.WORD_BITS(WORD), .FRAME_BITS(FRAME), .PRESET(PRESET)) uut (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .serial_in(serial_in),
    .word_data(word_data), .word_valid(word_valid), .locked(locked)
  );

  function automatic logic [31:0] slot_word(input int f, input int s);
    logic [19:0] fc;
    logic [3:0]  sn;
    fc = 20'(f);
    sn = 4'(s);
    return {8'hA5, fc, sn};
  endfunction

  function automatic logic frame_bit(input int f, input int p);
    logic [31:0] w;
    w = slot_word(f, p / 32);
    return w[31 - (p % 32)];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bit clock: drive, advance model, sample at the following negedge
  task automatic cycle(input logic r, input logic fs, input logic sd,
                       input bit align_chk, input int pos, input logic [31:0] slot_val);
    bit edge_seen;
    rst = r; frame_sync = fs; serial_in = sd;
    if (r) begin
      m_cnt = PRESET % FRAME; m_prev = 1; m_lock = 0; m_valid = 0; m_data = '0; m_sr = '0;
    end else begin
      edge_seen = fs && !m_prev;
      m_sr = {m_sr[30:0], sd};
      if (m_cnt % WORD == WORD - 1) begin m_valid = 1; m_data = m_sr; end
      else m_valid = 0;
      m_cnt = edge_seen ? 0 : (m_cnt + 1) % FRAME;
      if (edge_seen) m_lock = 1;
      m_prev = fs;
    end
    @(posedge clk);
    @(negedge clk);
    chk(word_valid == m_valid, "R2 R7 word_valid", 32'(word_valid), 32'(m_valid));
    chk(word_data == m_data,   "R2 R7 word_data",  word_data, m_data);
    chk(locked == m_lock,      "R6 locked",        32'(locked), 32'(m_lock));
    if (align_chk && !r) begin
      chk(word_valid == (pos % 32 == 31), "R4 R5 aligned strobe", 32'(word_valid), 32'(pos % 32 == 31));
      if (word_valid) chk(word_data == slot_val, "R4 R5 aligned word", word_data, slot_val);
    end
  endtask

  // frame f; sync_now: this frame is synced; sync_next: edge at its last bit
  task automatic send_frame(input int f, input bit sync_now, input bit sync_next, input bit align);
    for (int p = 0; p < 128; p++) begin
      logic fs;
      fs = (sync_now && p < 63) || (sync_next && p == 127);
      cycle(1'b0, fs, frame_bit(f, p), align, p, slot_word(f, p / 32));
    end
  endtask

  initial begin
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) cycle(1'b1, 1'b0, 1'b1, 0, 0, '0);
    chk(word_valid == 0 && locked == 0 && word_data == 0, "R1 reset state",
        {word_data[29:0], word_valid, locked}, 32'h0);

    // R3: free-running, misaligned; frames 0..2 without sync, edge at end of 2
    for (int f = 0; f < 3; f++) begin
      for (int p = 0; p < 128; p++) begin
        int g;
        logic fs;
        g  = f * 128 + p;
        fs = (f == 2 && p == 127);
        cycle(1'b0, fs, frame_bit(f, p), 0, p, '0);
        if (g == 17) chk(word_valid == 0, "R3 no early word", 32'(word_valid), 32'h0);
        if (g == 18) chk(word_valid == 1, "R3 first word after 19 bits", 32'(word_valid), 32'h1);
        if (g == 50) begin
          logic [31:0] w0, w1, rot;
          w0 = slot_word(0, 0); w1 = slot_word(0, 1);
          rot = {w0[12:0], w1[31:13]};
          chk(word_valid == 1 && word_data == rot, "R3 rotated word", word_data, rot);
        end
        if (g == 126) chk(locked == 0, "R6 no lock before edge", 32'(locked), 32'h0);
      end
    end
    chk(locked == 1, "R6 lock after first edge", 32'(locked), 32'h1);

    // R4 R5: synced 128-bit frames, edge coincides with slot-3 word completion
    for (int f = 3; f < 7; f++) send_frame(f, 1'b1, (f != 6), 1'b1);

    // R4: filler bits then an edge mid-word
    for (int i = 0; i < 7; i++) cycle(1'b0, (i == 6), 1'b1, 0, 0, '0);
    chk(locked == 1, "R6 lock held", 32'(locked), 32'h1);
    for (int f = 7; f < 10; f++) send_frame(f, 1'b1, (f != 9), 1'b1);

    // R6: reset with frame_sync held high, then held high: no lock
    for (int i = 0; i < 2; i++) cycle(1'b1, 1'b1, 1'b0, 0, 0, '0);
    chk(locked == 0 && word_valid == 0, "R1 reset clears lock", 32'(locked), 32'h0);
    for (int i = 0; i < 40; i++) cycle(1'b0, 1'b1, i[0], 0, 0, '0);
    chk(locked == 0, "R6 held-high level is no edge", 32'(locked), 32'h0);
    for (int i = 0; i < 40; i++) cycle(1'b0, (i < 5), i[1], 0, 0, '0);
    chk(locked == 0, "R6 falling edge is no edge", 32'(locked), 32'h0);

    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule